// File: doc/BRIEF.md
# Seven-Level Phase-Disposition PWM Gate Generator

This block produces the switch commands for a single-phase seven-level inverter. The inverter builds a stepped dc link from three equal isolated sources, joined in parallel or in series, and an H-bridge then gives that link its polarity. Inside the block a triangular carrier runs through three stacked bands of equal height, all in phase. A rectified sine reference, scaled by a modulation index, is compared against the three shifted copies. The number of copies that the reference lies above is the output level, 0 to 3. Each level maps to one fixed pattern on the source-combining switches. The polarity of the current half of the fundamental sets the H-bridge diagonal.

A three-state controller runs the H-bridge. ST_IDLE is entered from reset and whenever enable is low: every gate is off and the counters restart. The transition "start" leaves ST_IDLE on the first enabled edge, into ST_POS or ST_NEG as the present half of the reference requires. The transitions "flip to negative" (ST_POS to ST_NEG) and "flip to positive" (ST_NEG to ST_POS) are taken only on an edge where the newly computed level is zero. The transition "stop" returns from either drive state to ST_IDLE when enable is low.

The modulation index is an unsigned fraction of MW bits (value/2^MW). It is captured only while idle and on the edge that closes a fundamental period. One reference sample is held for one carrier period, and a fundamental lasts 4*QTR carrier periods. A carrier period is 2*BAND ticks, with one tick every DIV clocks, so a 50 MHz clock with DIV=195 and BAND=64 gives about 2 kHz.

Top module: `pdpwm_gate_gen`

## Requirements
- R1: The carrier phase counter advances once every DIV clocks and runs 0..2*BAND-1. The triangle value is the phase itself for phase <= BAND and 2*BAND minus the phase otherwise. Carrier k (k = 0,1,2) equals k*BAND plus the triangle value.
- R2: The sample index s advances, modulo 4*QTR, when the phase wraps. With N = 2*QTR, j = s mod N, i = min(j, N-j) and a = i*(N-i), the reference magnitude is floor(floor(3*BAND*16*a/(5*N*N-4*a)) * Mq / 2^MW). Mq is the held modulation index. Samples with s >= N belong to the negative half.
- R3: The level is the count of carriers k for which the magnitude is strictly greater than carrier k.
- R4: Source gates per level: level 0 all off; level 1 both paralleling gates on; level 2 only the bridging gate on; level 3 bridging and cascading gates on. No paralleling gate is on together with bridging or cascading.
- R5: H-bridge gates while enabled: level 0 turns on both low gates only. A nonzero level in the positive state turns on left-high and right-low. A nonzero level in the negative state turns on right-high and left-low. The high and low gates of one leg are never on together.
- R6: out_neg is 1 exactly in ST_NEG. On "start" the state follows the half of the present sample. Afterwards it takes a new half's polarity only on an edge whose new level is 0.
- R7: The modulation index is loaded on every edge with enable low and on the enabled edge where s wraps from 4*QTR-1 to 0. On all other edges it is held.
- R8: Reset, or enable low at an edge, clears every gate, level and out_neg on that edge and restarts the divider, phase and sample index at zero.
- R9: Every output is registered. After the e-th enabled edge since idle, the outputs reflect the counter state reached after e-1 enabled edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low forces idle |
| mod_idx | input | MW | Modulation index, unsigned fraction value/2^MW |
| g_par_lo | output | 1 | Paralleling gate, lower source pair |
| g_par_hi | output | 1 | Paralleling gate, upper source pair |
| g_bridge | output | 1 | Arm-bridging (series) gate |
| g_cascade | output | 1 | Cascading gate adding the middle source |
| hb_left_hi | output | 1 | H-bridge left leg, high switch |
| hb_left_lo | output | 1 | H-bridge left leg, low switch |
| hb_right_hi | output | 1 | H-bridge right leg, high switch |
| hb_right_lo | output | 1 | H-bridge right leg, low switch |
| level | output | 2 | Present output level 0..3 |
| out_neg | output | 1 | High while the negative half is driven |

## Verification
Two things happen on the edge that closes a fundamental period: a new modulation index is captured, and the H-bridge flips from negative to positive. Both depend on the sample wrap. The bench changes the index every few dozen cycles, so some changes land just before that edge. It checks that the level sequence uses the old index up to the wrap and the new one after it, and that the polarity changes on exactly that edge with level 0. A second clash is stop against a level step. Enable is dropped in the middle of a period, and the bench expects dark gates on the very next edge rather than the pending level.

// File: rtl/pdpwm_pkg.sv
package pdpwm_pkg;

    localparam int NCAR = 3;
    localparam int LVLW = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_POS  = 2'd1,
        ST_NEG  = 2'd2
    } hb_state_e;

    typedef struct packed {
        logic par_lo;
        logic par_hi;
        logic bridge;
        logic cascade;
    } src_gate_t;

    typedef struct packed {
        logic left_hi;
        logic left_lo;
        logic right_hi;
        logic right_lo;
    } hb_gate_t;

    function automatic src_gate_t src_decode(input logic [LVLW-1:0] lvl);
        src_gate_t g;
        g = '0;
        unique case (lvl)
            2'd0: g = '0;
            2'd1: begin
                g.par_lo = 1'b1;
                g.par_hi = 1'b1;
            end
            2'd2: g.bridge = 1'b1;
            2'd3: begin
                g.bridge  = 1'b1;
                g.cascade = 1'b1;
            end
            default: g = '0;
        endcase
        return g;
    endfunction

    function automatic hb_gate_t hb_decode(input logic [LVLW-1:0] lvl, input hb_state_e st);
        hb_gate_t g;
        g = '0;
        if (st != ST_IDLE) begin
            if (lvl == '0) begin
                g.left_lo  = 1'b1;
                g.right_lo = 1'b1;
            end else if (st == ST_POS) begin
                g.left_hi  = 1'b1;
                g.right_lo = 1'b1;
            end else begin
                g.right_hi = 1'b1;
                g.left_lo  = 1'b1;
            end
        end
        return g;
    endfunction

endpackage

// File: rtl/pdpwm_carrier.sv
module pdpwm_carrier #(
    parameter int BAND = 64,
    parameter int DIV  = 195,
    localparam int TW  = $clog2(BAND + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    output logic [TW-1:0] tri_val,
    output logic          period_end
);

    localparam int PHW  = $clog2(2 * BAND);
    localparam int DVW  = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int PH_LAST = 2 * BAND - 1;

    logic [DVW-1:0] div_q;
    logic [PHW-1:0] ph_q;
    logic           tick;

    assign tick = (div_q == DVW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            div_q <= '0;
            ph_q  <= '0;
        end else if (tick) begin
            div_q <= '0;
            ph_q  <= (ph_q == PHW'(PH_LAST)) ? '0 : ph_q + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    always_comb begin
        int ph_i;
        ph_i = int'(ph_q);
        if (ph_i <= BAND) tri_val = TW'(ph_i);
        else              tri_val = TW'(2 * BAND - ph_i);
    end

    assign period_end = tick && (ph_q == PHW'(PH_LAST));

    assert_tri_range_R1: assert property (@(posedge clk) disable iff (rst)
        int'(tri_val) <= BAND);

    assert_tri_step_R1: assert property (@(posedge clk) disable iff (rst)
        (en && tick) |=> (!en || (int'(tri_val) - int'($past(tri_val)) == 1)
                              || (int'($past(tri_val)) - int'(tri_val) == 1)));

    assert_tri_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> (!en || $stable(tri_val)));

endmodule

// File: rtl/pdpwm_ref.sv
module pdpwm_ref #(
    parameter int BAND = 64,
    parameter int QTR  = 10,
    parameter int MW   = 8,
    localparam int FS   = 3 * BAND,
    localparam int MAGW = $clog2(FS + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            period_end,
    input  logic [MW-1:0]   mod_idx,
    output logic [MAGW-1:0] mag,
    output logic            want_neg
);

    localparam int HALF = 2 * QTR;
    localparam int NSMP = 4 * QTR;
    localparam int SW   = $clog2(NSMP);
    localparam int PW   = MAGW + MW;

    function automatic int sine_pt(input int qi);
        int a;
        a = qi * (HALF - qi);
        return (FS * 16 * a) / (5 * HALF * HALF - 4 * a);
    endfunction

    logic [MAGW-1:0] qtab [QTR+1];

    for (genvar g = 0; g <= QTR; g++) begin : g_tab
        assign qtab[g] = MAGW'(sine_pt(g));
    end

    logic [SW-1:0]  s_q;
    logic [MW-1:0]  m_q;
    logic           fund_end;
    logic [PW-1:0]  prod;

    assign fund_end = period_end && (s_q == SW'(NSMP - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
            m_q <= '0;
        end else if (!en) begin
            s_q <= '0;
            m_q <= mod_idx;
        end else if (period_end) begin
            if (fund_end) begin
                s_q <= '0;
                m_q <= mod_idx;
            end else begin
                s_q <= s_q + 1'b1;
            end
        end
    end

    always_comb begin
        int s_i;
        int j;
        int qi;
        s_i      = int'(s_q);
        want_neg = (s_i >= HALF);
        j        = want_neg ? s_i - HALF : s_i;
        qi       = (j <= QTR) ? j : HALF - j;
        prod     = PW'(qtab[qi]) * PW'(m_q);
        mag      = MAGW'(prod >> MW);
    end

    assert_mag_range_R2: assert property (@(posedge clk) disable iff (rst)
        int'(mag) <= FS);

    assert_sample_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (en && !period_end) |=> (!en || $stable(s_q)));

    assert_mod_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (en && !fund_end) |=> (!en || $stable(m_q)));

endmodule

// File: rtl/pdpwm_level.sv
module pdpwm_level #(
    parameter int BAND = 64,
    localparam int TW   = $clog2(BAND + 1),
    localparam int MAGW = $clog2(3 * BAND + 1)
) (
    input  logic [MAGW-1:0]               mag,
    input  logic [TW-1:0]                 tri_val,
    output logic [pdpwm_pkg::LVLW-1:0]    lvl_nx
);

    import pdpwm_pkg::*;

    logic [NCAR-1:0] above;

    for (genvar k = 0; k < NCAR; k++) begin : g_car
        assign above[k] = int'(mag) > (k * BAND + int'(tri_val));
    end

    always_comb begin
        lvl_nx = '0;
        for (int k = 0; k < NCAR; k++) begin
            lvl_nx = lvl_nx + LVLW'(above[k]);
        end
    end

endmodule

// File: rtl/pdpwm_gate_fsm.sv
module pdpwm_gate_fsm
    import pdpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             want_neg,
    input  logic [LVLW-1:0]  lvl_nx,
    output src_gate_t        src_g,
    output hb_gate_t         hb_g,
    output logic [LVLW-1:0]  level_q,
    output logic             neg_q
);

    hb_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (en) state_nx = want_neg ? ST_NEG : ST_POS;
            end
            ST_POS: begin
                if (!en)                            state_nx = ST_IDLE;
                else if (want_neg && lvl_nx == '0)  state_nx = ST_NEG;
            end
            ST_NEG: begin
                if (!en)                            state_nx = ST_IDLE;
                else if (!want_neg && lvl_nx == '0) state_nx = ST_POS;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            src_g   <= '0;
            hb_g    <= '0;
            level_q <= '0;
        end else begin
            src_g   <= src_decode(lvl_nx);
            hb_g    <= hb_decode(lvl_nx, state_nx);
            level_q <= lvl_nx;
        end
    end

    assign neg_q = (state == ST_NEG);

    assert_flip_at_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (($past(state) == ST_POS && state == ST_NEG) ||
         ($past(state) == ST_NEG && state == ST_POS)) |-> (level_q == '0));

    assert_leg_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(hb_g.left_hi && hb_g.left_lo) && !(hb_g.right_hi && hb_g.right_lo));

    assert_src_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !((src_g.par_lo || src_g.par_hi) && (src_g.bridge || src_g.cascade)));

    assert_stop_dark_R8: assert property (@(posedge clk) disable iff (rst)
        !en |=> (src_g == '0 && hb_g == '0 && level_q == '0 && !neg_q));

endmodule

// File: rtl/pdpwm_gate_gen.sv
module pdpwm_gate_gen #(
    parameter int BAND = 64,
    parameter int DIV  = 195,
    parameter int QTR  = 10,
    parameter int MW   = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [MW-1:0] mod_idx,
    output logic          g_par_lo,
    output logic          g_par_hi,
    output logic          g_bridge,
    output logic          g_cascade,
    output logic          hb_left_hi,
    output logic          hb_left_lo,
    output logic          hb_right_hi,
    output logic          hb_right_lo,
    output logic [1:0]    level,
    output logic          out_neg
);

    import pdpwm_pkg::*;

    localparam int TW   = $clog2(BAND + 1);
    localparam int MAGW = $clog2(3 * BAND + 1);

    logic [TW-1:0]   tri_val;
    logic            period_end;
    logic [MAGW-1:0] mag;
    logic            want_neg;
    logic [LVLW-1:0] lvl_nx;
    logic [LVLW-1:0] level_q;
    src_gate_t       src_g;
    hb_gate_t        hb_g;

    pdpwm_carrier #(.BAND(BAND), .DIV(DIV)) u_car (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .tri_val    (tri_val),
        .period_end (period_end)
    );

    pdpwm_ref #(.BAND(BAND), .QTR(QTR), .MW(MW)) u_ref (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .period_end (period_end),
        .mod_idx    (mod_idx),
        .mag        (mag),
        .want_neg   (want_neg)
    );

    pdpwm_level #(.BAND(BAND)) u_lvl (
        .mag     (mag),
        .tri_val (tri_val),
        .lvl_nx  (lvl_nx)
    );

    pdpwm_gate_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .want_neg (want_neg),
        .lvl_nx   (lvl_nx),
        .src_g    (src_g),
        .hb_g     (hb_g),
        .level_q  (level_q),
        .neg_q    (out_neg)
    );

    assign g_par_lo    = src_g.par_lo;
    assign g_par_hi    = src_g.par_hi;
    assign g_bridge    = src_g.bridge;
    assign g_cascade   = src_g.cascade;
    assign hb_left_hi  = hb_g.left_hi;
    assign hb_left_lo  = hb_g.left_lo;
    assign hb_right_hi = hb_g.right_hi;
    assign hb_right_lo = hb_g.right_lo;
    assign level       = level_q;

endmodule

// File: tb/pdpwm_gate_gen_tb_top.sv
`timescale 1ns/1ps
module pdpwm_gate_gen_tb_top;

    localparam int B  = 4;
    localparam int Q  = 4;
    localparam int D  = 2;
    localparam int MW = 4;
    localparam int PERIOD_CLKS = 2 * B * 4 * Q * D;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic [MW-1:0] mod_idx = '0;
    logic g_par_lo, g_par_hi, g_bridge, g_cascade;
    logic hb_left_hi, hb_left_lo, hb_right_hi, hb_right_lo;
    logic [1:0] level;
    logic out_neg;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    int mdiv = 0, mph = 0, ms = 0, mlat = 0, mpol = 0;
    bit midle = 1'b1;

    always #10 clk = ~clk;

    pdpwm_gate_gen #(.BAND(B), .DIV(D), .QTR(Q), .MW(MW)) dut_i (
        .clk(clk), .rst(rst), .en(en), .mod_idx(mod_idx),
        .g_par_lo(g_par_lo), .g_par_hi(g_par_hi), .g_bridge(g_bridge), .g_cascade(g_cascade),
        .hb_left_hi(hb_left_hi), .hb_left_lo(hb_left_lo),
        .hb_right_hi(hb_right_hi), .hb_right_lo(hb_right_lo),
        .level(level), .out_neg(out_neg)
    );

    function automatic int ref_mag(input int s, input int m);
        int n, j, i, a, t;
        n = 2 * Q;
        j = s % n;
        i = (j < n - j) ? j : n - j;
        a = i * (n - i);
        t = (3 * B * 16 * a) / (5 * n * n - 4 * a);
        return (t * m) / (1 << MW);
    endfunction

    function automatic int exp_level(input int ph, input int s, input int m);
        int tri_v, mag, c;
        tri_v = (ph <= B) ? ph : 2 * B - ph;
        mag = ref_mag(s, m);
        c = 0;
        for (int k = 0; k < 3; k++) if (mag > k * B + tri_v) c++;
        return c;
    endfunction

    task automatic chk(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic cyc(input bit e_v, input int m_v);
        int el, en_, es, eh;
        bit want;
        en = e_v;
        mod_idx = MW'(m_v);
        if (!e_v) begin
            el = 0; en_ = 0; es = 0; eh = 0;
            mlat = m_v; mdiv = 0; mph = 0; ms = 0; midle = 1'b1;
        end else begin
            el = exp_level(mph, ms, mlat);
            want = (ms >= 2 * Q);
            if (midle || el == 0) mpol = want ? 1 : 0;
            midle = 1'b0;
            en_ = mpol;
            case (el)
                0: es = 4'b0000;
                1: es = 4'b1100;
                2: es = 4'b0010;
                default: es = 4'b0011;
            endcase
            if (el == 0)        eh = 4'b0101;
            else if (mpol == 0) eh = 4'b1001;
            else                eh = 4'b0110;
            if (mdiv == D - 1) begin
                mdiv = 0;
                if (mph == 2 * B - 1) begin
                    mph = 0;
                    if (ms == 4 * Q - 1) begin
                        ms = 0;
                        mlat = m_v;
                    end else ms++;
                end else mph++;
            end else mdiv++;
        end
        @(negedge clk);
        if (!e_v) begin
            chk("R8 idle level", int'(level), 0);
            chk("R8 idle polarity", int'(out_neg), 0);
            chk("R8 idle source gates", int'({g_par_lo, g_par_hi, g_bridge, g_cascade}), 0);
            chk("R8 idle bridge gates", int'({hb_left_hi, hb_left_lo, hb_right_hi, hb_right_lo}), 0);
        end else begin
            chk("R1 R2 R3 R7 R9 level", int'(level), el);
            chk("R6 polarity", int'(out_neg), en_);
            chk("R4 source gates", int'({g_par_lo, g_par_hi, g_bridge, g_cascade}), es);
            chk("R5 bridge gates", int'({hb_left_hi, hb_left_lo, hb_right_hi, hb_right_lo}), eh);
        end
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 reset source gates", int'({g_par_lo, g_par_hi, g_bridge, g_cascade}), 0);
        chk("R8 reset bridge gates", int'({hb_left_hi, hb_left_lo, hb_right_hi, hb_right_lo}), 0);
        chk("R8 reset level", int'(level), 0);
        chk("R8 reset polarity", int'(out_neg), 0);
        rst = 1'b0;
        repeat (4) cyc(1'b0, 0);

        // full sweep of the modulation index, one fundamental period each
        for (int m = 0; m < (1 << MW); m++) begin
            cyc(1'b0, m);
            for (int c = 0; c < PERIOD_CLKS + 8; c++) cyc(1'b1, m);
        end

        // index changes at arbitrary points: only period wraps take them (R7)
        cyc(1'b0, 9);
        for (int c = 0; c < 4 * PERIOD_CLKS; c++) cyc(1'b1, ((c / 37) * 5 + 3) % (1 << MW));

        // change right before and right after the period boundary
        cyc(1'b0, 15);
        for (int c = 0; c < PERIOD_CLKS - 1; c++) cyc(1'b1, 15);
        cyc(1'b1, 2);
        for (int c = 0; c < PERIOD_CLKS; c++) cyc(1'b1, (c == 0) ? 2 : 11);

        // stop in mid-period and restart (R8)
        for (int c = 0; c < 101; c++) cyc(1'b1, 13);
        repeat (3) cyc(1'b0, 13);
        for (int c = 0; c < 300; c++) cyc(1'b1, 13);
        cyc(1'b0, 7);
        for (int c = 0; c < 2 * PERIOD_CLKS; c++) cyc(1'b1, 7);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule